// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Event and Mask Registers

This block sits between a processor bus and the shift engine of an SPI controller. It holds a 32-byte transmit queue and a 32-byte receive queue. Software reaches both through one data address, using 8-, 16- or 32-bit accesses: a write appends bytes to the transmit queue and a read removes bytes from the receive queue. Bytes travel big-endian, so the most significant byte of the accessed width is always the first byte on the wire. The shift engine removes transmit bytes and appends receive bytes one at a time.

A status word reports how many transmit bytes are free and how many receive bytes are held, together with a set of sticky flags. A mask word selects which flags drive the single interrupt line. A mode word holds the enable and loop controls and the two programmable fill thresholds. The bus is a simple strobe interface: register address 0 is mode, 1 is status (events), 2 is mask and 3 is data; read data is combinational in the cycle of the read strobe and a data pop or push takes effect at the clock edge that ends that cycle.

Top module: `spi_byte_fifo`

## Requirements
- R1: While reset is held the status word reads 0x00200000 (32 free transmit bytes, no receive bytes, no flags), the mode word reads 0x0000040F (transmit threshold 4 in bits 13:8, receive threshold 15 in bits 5:0, enable bit 31 and loop bit 30 clear), the mask reads 0 and `irq` is low.
- R2: A data write pushes 1, 2 or 4 bytes for `cpuSize` 0, 1 or 2 (code 3 moves no data); the engine pops them in the order wdata[31:24],[23:16],[15:8],[7:0] for 4 bytes, [15:8],[7:0] for 2 bytes and [7:0] for 1 byte.
- R3: A data read pops 1, 2 or 4 receive bytes and returns the oldest byte in the most significant byte of the accessed width (bits 7:0, 15:8 or 31:24), zero-extended to 32 bits.
- R4: Status bits 29:24 give the held receive byte count and bits 21:16 the free transmit byte count; both follow every push and pop from the clock edge that performs it.
- R5: A data write needing more bytes than are free is dropped whole, and an engine push into a full receive queue is dropped; the queued bytes are unchanged.
- R6: A data read asking for more bytes than are held returns 0 and pops nothing; an engine pop from an empty transmit queue returns 0x00 and changes nothing.
- R7: Status flags sit at bit 15 transmit empty, 14 done, 13 receive threshold, 12 receive full, 11 transmit threshold, 9 receive not empty, 8 transmit not full (bit 10 always 0); each is set at the clock edge after its condition holds, stays set until a status write with a 1 in that bit, and a clear loses to a condition that still holds.
- R8: The receive threshold flag sets when the held count is greater than the receive threshold; the transmit threshold flag sets when the free count is at least the transmit threshold.
- R9: A one-cycle pulse on `engDone` sets the done flag (bit 14), and a status write of 1 to bit 14 clears it.
- R10: The mask word uses the flag bit positions (bits 15:8, bit 10 reads 0); `irq` is high exactly when some flag and its mask bit are both set.
- R11: The mode word reads back bits 31, 30, 13:8 and 5:0 as written (other bits read 0), and bits 31 and 30 drive `modeEnable` and `modeLoop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWr | input | 1 | Register write strobe |
| cpuRd | input | 1 | Register read strobe (pops on the data address) |
| cpuAddr | input | 2 | 0 mode, 1 status, 2 mask, 3 data |
| cpuSize | input | 2 | Data access width: 0 byte, 1 halfword, 2 word |
| cpuWdata | input | 32 | Write data |
| cpuRdata | output | 32 | Read data for the addressed register |
| engTxPop | input | 1 | Engine takes one transmit byte |
| engTxByte | output | 8 | Oldest transmit byte, 0 when empty |
| engRxPush | input | 1 | Engine delivers one receive byte |
| engRxByte | input | 8 | Receive byte from the engine |
| engDone | input | 1 | Engine end-of-transfer pulse |
| modeEnable | output | 1 | Mode enable bit |
| modeLoop | output | 1 | Mode loop bit |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch, on every cycle, that neither count leaves its range, that a push into a full receive queue leaves it full, that an accepted data write lowers the free count by exactly its width, that an empty transmit queue hands out zero, that a done pulse always lands in the status word and that clearing the mask silences the interrupt. Byte order across the three access widths, the exact threshold boundaries, the stickiness of flags after their condition goes away and the read-back of register fields need a known history of pushes and pops, so only the directed scenarios of the bench show them.

// File: rtl/spi_byte_fifo_pkg.sv
package spi_byte_fifo_pkg;

  // register addresses
  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_EVENT = 2'd1;
  localparam logic [1:0] ADDR_MASK  = 2'd2;
  localparam logic [1:0] ADDR_DATA  = 2'd3;

  // flag index inside the 8-bit flag byte (status bits 15:8)
  localparam int FLG_TXE = 7;
  localparam int FLG_DON = 6;
  localparam int FLG_RXT = 5;
  localparam int FLG_RXF = 4;
  localparam int FLG_TXT = 3;
  localparam int FLG_RNE = 1;
  localparam int FLG_TNF = 0;
  localparam logic [7:0] FLAG_LIVE = 8'hFB;

  localparam int THR_W = 6;
  localparam logic [THR_W-1:0] TXTHR_RST = 6'd4;
  localparam logic [THR_W-1:0] RXTHR_RST = 6'd15;

  // strobes from control to datapath
  typedef struct packed {
    logic [2:0]  txPushN;
    logic [31:0] txPushData;  // first byte in [31:24]
    logic [2:0]  rxPopN;
  } fifoStrobe_t;

endpackage

// File: rtl/sbf_byte_fifo.sv
module sbf_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    pushN,
  input  logic [31:0]   pushData,
  input  logic [2:0]    popN,
  output logic [31:0]   peek,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < pushN) mem[wrPtr + PW'(k)] <= pushData[31-8*k -: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PW'(pushN);
      rdPtr <= rdPtr + PW'(popN);
      count <= count + CW'(pushN) - CW'(popN);
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) peek[31-8*k -: 8] = mem[rdPtr + PW'(k)];
  end
endmodule

// File: rtl/sbf_datapath.sv
module sbf_datapath
  import spi_byte_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strobe,
  input  logic          engTxPop,
  output logic [7:0]    engTxByte,
  input  logic          engRxPush,
  input  logic [7:0]    engRxByte,
  output logic [31:0]   rxPeek,
  output logic [CW-1:0] txFree,
  output logic [CW-1:0] rxCount
);
  logic [CW-1:0] txCount;
  logic [31:0]   txPeek;
  logic          txHasData;
  logic          rxHasRoom;
  logic [23:0]   unusedTxPeek;

  assign txHasData    = txCount != '0;
  assign rxHasRoom    = rxCount != CW'(DEPTH);
  assign txFree       = CW'(DEPTH) - txCount;
  assign engTxByte    = txHasData ? txPeek[31:24] : 8'h00;
  assign unusedTxPeek = txPeek[23:0];

  sbf_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk      (clk),
    .rstN     (rstN),
    .pushN    (strobe.txPushN),
    .pushData (strobe.txPushData),
    .popN     ((engTxPop && txHasData) ? 3'd1 : 3'd0),
    .peek     (txPeek),
    .count    (txCount)
  );

  sbf_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk      (clk),
    .rstN     (rstN),
    .pushN    ((engRxPush && rxHasRoom) ? 3'd1 : 3'd0),
    .pushData ({engRxByte, 24'h0}),
    .popN     (strobe.rxPopN),
    .peek     (rxPeek),
    .count    (rxCount)
  );
endmodule

// File: rtl/sbf_ctrl.sv
module sbf_ctrl
  import spi_byte_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuWr,
  input  logic          cpuRd,
  input  logic [1:0]    cpuAddr,
  input  logic [1:0]    cpuSize,
  input  logic [31:0]   cpuWdata,
  output logic [31:0]   cpuRdata,
  input  logic          engDone,
  input  logic [CW-1:0] txFree,
  input  logic [CW-1:0] rxCount,
  input  logic [31:0]   rxPeek,
  output fifoStrobe_t   strobe,
  output logic          modeEnable,
  output logic          modeLoop,
  output logic [7:0]    evFlags,
  output logic          irq
);
  logic [THR_W-1:0] txThr;
  logic [THR_W-1:0] rxThr;
  logic [7:0]       maskBits;
  logic [7:0]       flagCond;
  logic [7:0]       flagClr;
  logic [2:0]       nBytes;
  logic             txFits;
  logic             rxEnough;
  logic [31:0]      pushAligned;
  logic [31:0]      popAligned;
  logic [5:0]       rxField;
  logic [5:0]       txField;

  always_comb begin
    case (cpuSize)
      2'd0:    nBytes = 3'd1;
      2'd1:    nBytes = 3'd2;
      2'd2:    nBytes = 3'd4;
      default: nBytes = 3'd0;
    endcase
  end

  assign txFits   = (nBytes != 3'd0) && (txFree >= CW'(nBytes));
  assign rxEnough = (nBytes != 3'd0) && (rxCount >= CW'(nBytes));

  always_comb begin
    case (cpuSize)
      2'd0:    pushAligned = {cpuWdata[7:0], 24'h0};
      2'd1:    pushAligned = {cpuWdata[15:0], 16'h0};
      default: pushAligned = cpuWdata;
    endcase
    case (cpuSize)
      2'd0:    popAligned = {24'h0, rxPeek[31:24]};
      2'd1:    popAligned = {16'h0, rxPeek[31:16]};
      default: popAligned = rxPeek;
    endcase
  end

  assign strobe.txPushN    = (cpuWr && cpuAddr == ADDR_DATA && txFits) ? nBytes : 3'd0;
  assign strobe.txPushData = pushAligned;
  assign strobe.rxPopN     = (cpuRd && cpuAddr == ADDR_DATA && rxEnough) ? nBytes : 3'd0;

  // live conditions that set the sticky flags
  always_comb begin
    flagCond          = 8'h00;
    flagCond[FLG_TXE] = txFree == CW'(DEPTH);
    flagCond[FLG_DON] = engDone;
    flagCond[FLG_RXT] = 7'(rxCount) > 7'(rxThr);
    flagCond[FLG_RXF] = rxCount == CW'(DEPTH);
    flagCond[FLG_TXT] = 7'(txFree) >= 7'(txThr);
    flagCond[FLG_RNE] = rxCount != '0;
    flagCond[FLG_TNF] = txFree != '0;
  end

  assign flagClr = (cpuWr && cpuAddr == ADDR_EVENT) ? cpuWdata[15:8] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEnable <= 1'b0;
      modeLoop   <= 1'b0;
      txThr      <= TXTHR_RST;
      rxThr      <= RXTHR_RST;
      maskBits   <= 8'h00;
      evFlags    <= 8'h00;
    end else begin
      evFlags <= ((evFlags & ~flagClr) | flagCond) & FLAG_LIVE;
      if (cpuWr && cpuAddr == ADDR_MODE) begin
        modeEnable <= cpuWdata[31];
        modeLoop   <= cpuWdata[30];
        txThr      <= cpuWdata[13:8];
        rxThr      <= cpuWdata[5:0];
      end
      if (cpuWr && cpuAddr == ADDR_MASK) maskBits <= cpuWdata[15:8] & FLAG_LIVE;
    end
  end

  assign irq     = |(evFlags & maskBits);
  assign rxField = 6'(rxCount);
  assign txField = 6'(txFree);

  always_comb begin
    case (cpuAddr)
      ADDR_MODE:  cpuRdata = {modeEnable, modeLoop, 16'h0, txThr, 2'b00, rxThr};
      ADDR_EVENT: cpuRdata = {2'b00, rxField, 2'b00, txField, evFlags, 8'h00};
      ADDR_MASK:  cpuRdata = {16'h0, maskBits, 8'h00};
      default:    cpuRdata = rxEnough ? popAligned : 32'h0;
    endcase
  end
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
  import spi_byte_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuWr,
  input  logic        cpuRd,
  input  logic [1:0]  cpuAddr,
  input  logic [1:0]  cpuSize,
  input  logic [31:0] cpuWdata,
  output logic [31:0] cpuRdata,
  input  logic        engTxPop,
  output logic [7:0]  engTxByte,
  input  logic        engRxPush,
  input  logic [7:0]  engRxByte,
  input  logic        engDone,
  output logic        modeEnable,
  output logic        modeLoop,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobe_t   strobe;
  logic [CW-1:0] txFree;
  logic [CW-1:0] rxCount;
  logic [31:0]   rxPeek;
  logic [7:0]    evFlags;

  sbf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuWr      (cpuWr),
    .cpuRd      (cpuRd),
    .cpuAddr    (cpuAddr),
    .cpuSize    (cpuSize),
    .cpuWdata   (cpuWdata),
    .cpuRdata   (cpuRdata),
    .engDone    (engDone),
    .txFree     (txFree),
    .rxCount    (rxCount),
    .rxPeek     (rxPeek),
    .strobe     (strobe),
    .modeEnable (modeEnable),
    .modeLoop   (modeLoop),
    .evFlags    (evFlags),
    .irq        (irq)
  );

  sbf_datapath #(.DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .engTxPop  (engTxPop),
    .engTxByte (engTxByte),
    .engRxPush (engRxPush),
    .engRxByte (engRxByte),
    .rxPeek    (rxPeek),
    .txFree    (txFree),
    .rxCount   (rxCount)
  );
endmodule

// File: rtl/spi_byte_fifo_chk.sv
module spi_byte_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuWr,
  input logic          cpuRd,
  input logic [1:0]    cpuAddr,
  input logic [1:0]    cpuSize,
  input logic [31:0]   cpuWdata,
  input logic          engTxPop,
  input logic [7:0]    engTxByte,
  input logic          engRxPush,
  input logic          engDone,
  input logic          irq,
  input logic [CW-1:0] txFree,
  input logic [CW-1:0] rxCount,
  input logic [7:0]    evFlags
);
  int accBytes;
  always_comb begin
    case (cpuSize)
      2'd0:    accBytes = 1;
      2'd1:    accBytes = 2;
      2'd2:    accBytes = 4;
      default: accBytes = 0;
    endcase
  end

  // R4 R5: counts stay in range
  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txFree) <= DEPTH) && (int'(rxCount) <= DEPTH));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && int'(rxCount) == DEPTH && !(cpuRd && cpuAddr == 2'd3))
    |=> int'(rxCount) == DEPTH);

  assert_push_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == 2'd3 && accBytes != 0 && int'(txFree) >= accBytes && !engTxPop)
    |=> int'(txFree) == int'($past(txFree)) - $past(accBytes));

  assert_empty_pop_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (engTxPop && int'(txFree) == DEPTH) |-> engTxByte == 8'h00);

  assert_done_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    engDone |=> evFlags[6]);

  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == 2'd2 && cpuWdata[15:8] == 8'h00) |=> !irq);
endmodule

bind spi_byte_fifo spi_byte_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuWr     (cpuWr),
  .cpuRd     (cpuRd),
  .cpuAddr   (cpuAddr),
  .cpuSize   (cpuSize),
  .cpuWdata  (cpuWdata),
  .engTxPop  (engTxPop),
  .engTxByte (engTxByte),
  .engRxPush (engRxPush),
  .engDone   (engDone),
  .irq       (irq),
  .txFree    (txFree),
  .rxCount   (rxCount),
  .evFlags   (evFlags)
);

// File: tb/spi_byte_fifo_tb.sv
`timescale 1ns/1ps
module spi_byte_fifo_tb;
  localparam logic [1:0] A_MODE = 2'd0, A_EV = 2'd1, A_MASK = 2'd2, A_DATA = 2'd3;
  localparam logic [1:0] SZ1 = 2'd0, SZ2 = 2'd1, SZ4 = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuWr = 1'b0, cpuRd = 1'b0;
  logic [1:0] cpuAddr = 2'd0, cpuSize = 2'd2;
  logic [31:0] cpuWdata = 32'h0;
  logic [31:0] cpuRdata;
  logic engTxPop = 1'b0;
  logic [7:0] engTxByte;
  logic engRxPush = 1'b0;
  logic [7:0] engRxByte = 8'h0;
  logic engDone = 1'b0;
  logic modeEnable, modeLoop, irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  spi_byte_fifo u_dut (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr),
    .cpuSize(cpuSize), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .engTxPop(engTxPop), .engTxByte(engTxByte), .engRxPush(engRxPush),
    .engRxByte(engRxByte), .engDone(engDone), .modeEnable(modeEnable),
    .modeLoop(modeLoop), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpuWrite(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuSize = sz; cpuWdata = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic cpuRead(input logic [1:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuSize = sz; cpuRd = 1'b1;
    #1 d = cpuRdata;
    @(negedge clk);
    cpuRd = 1'b0;
  endtask

  task automatic regPeek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuSize = SZ4;
    #1 d = cpuRdata;
  endtask

  task automatic engPop(output logic [7:0] b);
    @(negedge clk);
    engTxPop = 1'b1;
    #1 b = engTxByte;
    @(negedge clk);
    engTxPop = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b);
    @(negedge clk);
    engRxByte = b; engRxPush = 1'b1;
    @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    engDone = 1'b1;
    @(negedge clk);
    engDone = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    regPeek(A_EV, v);   chk("R1", "status in reset", v, 32'h0020_0000);
    regPeek(A_MODE, v); chk("R1", "mode in reset", v, 32'h0000_040F);
    regPeek(A_MASK, v); chk("R1", "mask in reset", v, 32'h0);
    chk("R1", "irq in reset", {31'h0, irq}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    tick(2);
  endtask

  task automatic test_tx_order();
    logic [31:0] v;
    logic [7:0] b;
    logic [7:0] exp [7] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h55, 8'h66, 8'h77};
    cpuWrite(A_DATA, SZ4, 32'hA1B2_C3D4);
    cpuWrite(A_DATA, SZ2, 32'hFFFF_5566);
    cpuWrite(A_DATA, SZ1, 32'hFFFF_FF77);
    regPeek(A_EV, v);
    chk("R4", "tx free after 7 bytes", {26'h0, v[21:16]}, 32'd25);
    chk("R4", "rx held while idle", {26'h0, v[29:24]}, 32'd0);
    for (int i = 0; i < 7; i++) begin
      engPop(b);
      chk("R2", $sformatf("tx byte %0d", i), {24'h0, b}, {24'h0, exp[i]});
    end
    regPeek(A_EV, v);
    chk("R4", "tx free after drain", {26'h0, v[21:16]}, 32'd32);
  endtask

  task automatic test_rx_order();
    logic [31:0] v;
    for (int i = 0; i < 7; i++) engPush(8'(8'h10 + i));
    regPeek(A_EV, v);
    chk("R4", "rx held after 7 pushes", {26'h0, v[29:24]}, 32'd7);
    cpuRead(A_DATA, SZ4, v); chk("R3", "word read", v, 32'h1011_1213);
    cpuRead(A_DATA, SZ2, v); chk("R3", "halfword read", v, 32'h0000_1415);
    cpuRead(A_DATA, SZ1, v); chk("R3", "byte read", v, 32'h0000_0016);
    regPeek(A_EV, v);
    chk("R4", "rx held after drain", {26'h0, v[29:24]}, 32'd0);
  endtask

  task automatic test_underflow();
    logic [31:0] v;
    logic [7:0] b;
    cpuRead(A_DATA, SZ2, v); chk("R6", "read of empty rx", v, 32'h0);
    engPush(8'h5A);
    cpuRead(A_DATA, SZ2, v); chk("R6", "halfword read with one byte", v, 32'h0);
    regPeek(A_EV, v); chk("R6", "short read pops nothing", {26'h0, v[29:24]}, 32'd1);
    cpuRead(A_DATA, SZ1, v); chk("R6", "byte kept after short read", v, 32'h0000_005A);
    engPop(b); chk("R6", "pop of empty tx", {24'h0, b}, 32'h0);
    regPeek(A_EV, v); chk("R6", "empty pop leaves tx free", {26'h0, v[21:16]}, 32'd32);
  endtask

  task automatic test_overflow();
    logic [31:0] v;
    logic [7:0] b;
    for (int i = 0; i < 8; i++)
      cpuWrite(A_DATA, SZ4, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
    cpuWrite(A_DATA, SZ1, 32'h0000_00EE);
    regPeek(A_EV, v); chk("R5", "tx full free count", {26'h0, v[21:16]}, 32'd0);
    engPop(b); chk("R5", "first byte of full queue", {24'h0, b}, 32'h0);
    cpuWrite(A_DATA, SZ2, 32'h0000_BBBB);
    regPeek(A_EV, v); chk("R5", "oversized write dropped", {26'h0, v[21:16]}, 32'd1);
    cpuWrite(A_DATA, SZ1, 32'h0000_00EE);
    for (int i = 1; i < 32; i++) begin
      engPop(b); chk("R5", $sformatf("tx byte %0d kept", i), {24'h0, b}, 32'(i));
    end
    engPop(b); chk("R5", "byte written into last slot", {24'h0, b}, 32'h0000_00EE);
    for (int i = 0; i < 33; i++) engPush(8'(8'h80 + i));
    tick(1);
    regPeek(A_EV, v);
    chk("R5", "rx held when full", {26'h0, v[29:24]}, 32'd32);
    chk("R7", "rx full flag bit 12", {31'h0, v[12]}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      cpuRead(A_DATA, SZ4, v);
      chk("R5", $sformatf("rx word %0d", i), v,
          {8'(8'h80+4*i), 8'(8'h81+4*i), 8'(8'h82+4*i), 8'(8'h83+4*i)});
    end
    cpuRead(A_DATA, SZ1, v); chk("R5", "extra push was dropped", v, 32'h0);
  endtask

  task automatic test_flags();
    logic [31:0] v;
    logic [7:0] b;
    cpuWrite(A_EV, SZ4, 32'h0000_FF00);
    tick(1);
    regPeek(A_EV, v); chk("R7", "idle flag byte after clear", {24'h0, v[15:8]}, 32'h89);
    for (int i = 0; i < 15; i++) engPush(8'(i));
    tick(1);
    regPeek(A_EV, v);
    chk("R8", "rx threshold clear at count 15", {31'h0, v[13]}, 32'd0);
    chk("R7", "rx not empty bit 9", {31'h0, v[9]}, 32'd1);
    engPush(8'hFF);
    tick(1);
    regPeek(A_EV, v); chk("R8", "rx threshold set at count 16", {31'h0, v[13]}, 32'd1);
    for (int i = 0; i < 4; i++) cpuRead(A_DATA, SZ4, v);
    tick(1);
    regPeek(A_EV, v);
    chk("R7", "rx threshold sticky after drain", {31'h0, v[13]}, 32'd1);
    chk("R7", "rx not empty sticky after drain", {31'h0, v[9]}, 32'd1);
    cpuWrite(A_EV, SZ4, 32'h0000_2200);
    tick(1);
    regPeek(A_EV, v); chk("R7", "cleared flags stay clear", {30'h0, v[13], v[9]}, 32'd0);
    cpuWrite(A_MODE, SZ4, 32'h0000_1E0F);
    cpuWrite(A_DATA, SZ2, 32'h0000_0102);
    cpuWrite(A_DATA, SZ1, 32'h0000_0003);
    cpuWrite(A_EV, SZ4, 32'h0000_0800);
    tick(1);
    regPeek(A_EV, v); chk("R8", "tx threshold clear at free 29", {31'h0, v[11]}, 32'd0);
    engPop(b);
    tick(1);
    regPeek(A_EV, v); chk("R8", "tx threshold set at free 30", {31'h0, v[11]}, 32'd1);
    engPop(b); engPop(b);
    cpuWrite(A_MODE, SZ4, 32'h0000_040F);
  endtask

  task automatic test_done();
    logic [31:0] v;
    pulseDone();
    regPeek(A_EV, v); chk("R9", "done flag set", {31'h0, v[14]}, 32'd1);
    cpuWrite(A_EV, SZ4, 32'h0000_4000);
    tick(1);
    regPeek(A_EV, v); chk("R9", "done flag cleared", {31'h0, v[14]}, 32'd0);
  endtask

  task automatic test_irq();
    logic [31:0] v;
    cpuWrite(A_MASK, SZ4, 32'h0);
    cpuWrite(A_EV, SZ4, 32'h0000_FF00);
    #1 chk("R10", "irq with mask zero", {31'h0, irq}, 32'd0);
    cpuWrite(A_MASK, SZ4, 32'h0000_4000);
    regPeek(A_MASK, v); chk("R10", "mask readback", v, 32'h0000_4000);
    chk("R10", "irq with done masked in but clear", {31'h0, irq}, 32'd0);
    pulseDone();
    #1 chk("R10", "irq on done", {31'h0, irq}, 32'd1);
    cpuWrite(A_EV, SZ4, 32'h0000_4000);
    #1 chk("R10", "irq after done cleared", {31'h0, irq}, 32'd0);
    cpuWrite(A_MASK, SZ4, 32'h0000_8000);
    #1 chk("R10", "irq on tx empty", {31'h0, irq}, 32'd1);
    cpuWrite(A_MASK, SZ4, 32'h0);
    #1 chk("R10", "irq masked off", {31'h0, irq}, 32'd0);
  endtask

  task automatic test_mode();
    logic [31:0] v;
    cpuWrite(A_MODE, SZ4, 32'hC000_1E07);
    regPeek(A_MODE, v); chk("R11", "mode readback", v, 32'hC000_1E07);
    chk("R11", "enable and loop outputs", {30'h0, modeEnable, modeLoop}, 32'd3);
    cpuWrite(A_MODE, SZ4, 32'hFFFF_FFFF);
    regPeek(A_MODE, v); chk("R11", "unused mode bits read 0", v, 32'hC000_3F3F);
    cpuWrite(A_MODE, SZ4, 32'h0000_040F);
    #1 chk("R11", "outputs cleared", {30'h0, modeEnable, modeLoop}, 32'd0);
  endtask

  initial begin
    tick(3);
    test_reset();
    test_tx_order();
    test_rx_order();
    test_underflow();
    test_overflow();
    test_flags();
    test_done();
    test_irq();
    test_mode();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule